// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Increment Converters

This block is a purely combinational 128-bit adder. It takes two 128-bit operands and a carry-in, and it returns a 128-bit sum and a carry-out.

The word is split into sixteen groups whose widths grow toward the most significant end. The lowest group is a plain ripple adder fed by the external carry-in. Every higher group ripples its operands once, with its carry-in tied low. It then forms the carry-in-high answer by passing that (n+1)-bit result through an increment-by-one converter, so no second ripple adder is needed. A 2-to-1 selector, steered by the carry that leaves the group below, picks one of the two answers.

The group widths come from a sixteen-entry parameter. Because the groups grow in width, the select carry and each group's local ripple arrive at about the same time.

Top module: `sqcsel_adder`

## Requirements
- R1: {cout, sum} equals the 129-bit arithmetic value a + b + cin for every input combination.
- R2: The least significant group ripples directly from cin, so a = 0, b = 0, cin = 1 gives sum = 1 and cout = 0.
- R3: The group widths default, from LSB to MSB, to 2,2,3,4,5,6,7,8,9,10,11,11,12,12,13,13. A carry produced just below any group boundary reaches the first bit of the next group: a = 2^k − 1 with b = 1 gives sum = 2^k for every boundary position k.
- R4: In each upper group, the carry-in-high result equals the carry-in-low (n+1)-bit result plus one. This includes the case where the low n result bits are all ones, in which the increment carries into the group's carry bit.
- R5: Each upper group outputs its carry-in-low result when the carry from the group below is 0, and the incremented result when that carry is 1.
- R6: a = 2^128 − 1 with b = 0 and cin = 1 gives sum = 0 and cout = 1. A carry entering at bit 0 ripples through every group.
- R7: a = 0, b = 0, cin = 0 gives sum = 0 and cout = 0.
- R8: cout is the carry bit selected in the most significant group. For example, a = b = 2^127 with cin = 0 gives sum = 0 and cout = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 128 | First operand |
| b | input | 128 | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | 128 | Sum bits |
| cout | output | 1 | Carry out of bit 127 |

## Verification
Two events can coincide in one evaluation: a group's selector switches to the incremented path, and that path's increment carries into the group's own carry bit. When both happen, the carry into the next group changes as well.

The bench provokes this overlap with an all-ones low run ending at each group boundary, with a fully propagating all-ones operand, and with random operand pairs where one word is often the complement of the other. Every result is judged against a 129-bit behavioural addition.

// File: rtl/sqcsel_pkg.sv
package sqcsel_pkg;
    localparam int unsigned NGRP  = 16;
    localparam int unsigned WIDTH = 128;
    typedef int unsigned grp_sizes_t [NGRP];
    localparam grp_sizes_t DEF_SIZES = '{2, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 11, 12, 12, 13, 13};
endpackage

// File: rtl/sqcsel_rca.sv
module sqcsel_rca #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         ci,
    output logic [N-1:0] s,
    output logic         co
);
    logic [N:0] c;
    assign c[0] = ci;

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign s[i]   = a[i] ^ b[i] ^ c[i];
        assign c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
    end

    assign co = c[N];

    // R2: the ripple chain yields the arithmetic sum of its inputs
    always_comb begin
        p_rca_sum_r2: assert ({co, s} == ({1'b0, a} + {1'b0, b} + (N+1)'(ci)))
            else $error("ripple sum mismatch");
    end
endmodule

// File: rtl/sqcsel_incr.sv
module sqcsel_incr #(
    parameter int unsigned M = 5
) (
    input  logic [M-1:0] x,
    output logic [M-1:0] y
);
    logic [M:0] all_low;
    assign all_low[0] = 1'b1;

    for (genvar i = 0; i < M; i++) begin : g_bit
        assign y[i]           = x[i] ^ all_low[i];
        assign all_low[i+1]   = all_low[i] & x[i];
    end

    // R4: converter output is the input plus one, modulo 2^M
    always_comb begin
        p_incr_plus_one_r4: assert (y == x + M'(1))
            else $error("increment converter mismatch");
    end
endmodule

// File: rtl/sqcsel_group.sv
module sqcsel_group #(
    parameter int unsigned N = 4
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         sel,
    output logic [N-1:0] s,
    output logic         co
);
    logic [N-1:0] s_lo;
    logic         c_lo;
    logic [N:0]   r_lo;
    logic [N:0]   r_hi;

    sqcsel_rca #(.N(N)) u_rca (
        .a  (a),
        .b  (b),
        .ci (1'b0),
        .s  (s_lo),
        .co (c_lo)
    );

    assign r_lo = {c_lo, s_lo};

    sqcsel_incr #(.M(N + 1)) u_inc (
        .x (r_lo),
        .y (r_hi)
    );

    assign {co, s} = sel ? r_hi : r_lo;

    // R5: selected group result matches a + b + incoming carry
    always_comb begin
        p_group_select_r5: assert ({co, s} == ({1'b0, a} + {1'b0, b} + (N+1)'(sel)))
            else $error("group select mismatch");
    end
endmodule

// File: rtl/sqcsel_adder.sv
module sqcsel_adder
    import sqcsel_pkg::*;
#(
    parameter int unsigned W      = WIDTH,
    parameter int unsigned G      = NGRP,
    parameter grp_sizes_t  GSIZES = DEF_SIZES
) (
    input  logic [127:0] a,
    input  logic [127:0] b,
    input  logic         cin,
    output logic [127:0] sum,
    output logic         cout
);
    function automatic int unsigned base_of(input int unsigned k);
        int unsigned acc = 0;
        for (int unsigned i = 0; i < k; i++) acc += GSIZES[i];
        return acc;
    endfunction

    localparam int unsigned TOTAL = base_of(G);

    logic [G:0] gc;
    assign gc[0] = cin;

    for (genvar g = 0; g < G; g++) begin : g_grp
        localparam int unsigned LO = base_of(g);
        localparam int unsigned SZ = GSIZES[g];
        if (g == 0) begin : g_first
            sqcsel_rca #(.N(SZ)) u_first (
                .a  (a[LO +: SZ]),
                .b  (b[LO +: SZ]),
                .ci (gc[g]),
                .s  (sum[LO +: SZ]),
                .co (gc[g+1])
            );
        end else begin : g_sel
            sqcsel_group #(.N(SZ)) u_grp (
                .a   (a[LO +: SZ]),
                .b   (b[LO +: SZ]),
                .sel (gc[g]),
                .s   (sum[LO +: SZ]),
                .co  (gc[g+1])
            );
        end
    end

    assign cout = gc[G];

    // R1 / R8: full-width result and carry-out equal the arithmetic sum
    always_comb begin
        p_total_sum_r1: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + 129'(cin)))
            else $error("adder total mismatch");
        p_width_r3: assert (TOTAL == W)
            else $error("group sizes do not cover the word");
    end
endmodule

// File: tb/sqcsel_adder_test.sv
module sqcsel_adder_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [127:0] a = '0;
    logic [127:0] b = '0;
    logic         cin = 1'b0;
    logic [127:0] sum;
    logic         cout;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2.5 clk = ~clk;

    sqcsel_adder uut (
        .a    (a),
        .b    (b),
        .cin  (cin),
        .sum  (sum),
        .cout (cout)
    );

    function automatic logic [128:0] ref_add(input logic [127:0] x, input logic [127:0] y, input logic c);
        return {1'b0, x} + {1'b0, y} + 129'(c);
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic apply(input string tag, input logic [127:0] x, input logic [127:0] y, input logic c);
        logic [128:0] exp;
        @(posedge clk);
        a = x; b = y; cin = c;
        @(negedge clk);
        exp = ref_add(x, y, c);
        n_checks++;
        if ({cout, sum} !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, {cout, sum}, exp);
        end
    endtask

    int unsigned sizes [16] = '{2, 2, 3, 4, 5, 6, 7, 8, 9, 10, 11, 11, 12, 12, 13, 13};

    initial begin
        void'($urandom(32'h5a17));
        // R7: zero inputs during reset give a zero result
        @(negedge clk);
        n_checks++;
        if ({cout, sum} !== 129'd0) begin
            n_fail++;
            $display("FAIL R7: actual %h expected 0", {cout, sum});
        end
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        apply("R7", '0, '0, 1'b0);
        apply("R2", '0, '0, 1'b1);
        apply("R6", '1, '0, 1'b1);
        apply("R6", '0, '1, 1'b1);
        apply("R1", '1, '1, 1'b1);
        apply("R8", 128'd1 << 127, 128'd1 << 127, 1'b0);
        begin
            int unsigned bnd = 0;
            for (int k = 1; k < 16; k++) begin
                bnd += sizes[k-1];
                // R3 / R4 / R5: carry produced below each boundary
                apply("R3", (128'd1 << bnd) - 128'd1, 128'd1, 1'b0);
                apply("R4", (128'd1 << bnd) - 128'd1, 128'd0, 1'b1);
                apply("R5", (128'd1 << bnd) - 128'd2, 128'd1, 1'b0);
            end
        end
        for (int i = 0; i < 400; i++) begin
            logic [127:0] x = rnd128();
            logic [127:0] y = ($urandom % 3 == 0) ? ~x : rnd128();
            apply("R1", x, y, 1'(($urandom)));
        end
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 50000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule